// File: doc/BRIEF.md
# Multi-Lane Bonded Synchronizer

This block watches the character stream of several receive lanes, each already decoded into per-character flags. For every lane it tracks word synchronization through four stages: searching, acquiring, waiting for alignment, and locked. The progress toward alignment is made by counting back-to-back comma characters. Each lane reports its stage on a three-bit status code made of an error bit, a frame bit and a comma bit. It also raises a loss-of-lock flag that follows the lane's PLL without waiting for a clock.

In bonded mode the lanes form one wide link. Each lane reaches the waiting-for-alignment stage on its own. The locked stage is entered on all lanes in the same cycle, and only once the external deskew logic reports that the lanes are aligned and every lane presents a clean data character. While locked, the block runs an error monitor on each lane. If any lane sees too many decode errors, or any lane loses PLL lock, all lanes fall back to searching together. In independent mode each lane locks and unlocks by itself, and a lane whose PLL is unlocked shows a dedicated code.

Both error criteria are counted between comma characters. One is a run of consecutive decode errors. The other is an error count inside a fixed block of codewords. Holding the reference-clock enable low for long enough forces every lane back to searching, and so does the synchronous reset.

Top module: `lane_bond_sync`

## Requirements
- R1: While `rst` is high, and on the cycle after it, every lane is in the searching state and every lane's status is 000. Lane i's status sits at `status_o[3*i+2]` (err), `status_o[3*i+1]` (eof) and `status_o[3*i]` (kflag).
- R2: A valid comma seen by a lane in the searching or acquiring state moves it to acquiring, and the lane reports 011 in the following cycle.
- R3: A lane that receives ACQ_COMMAS (default 4) valid commas back to back enters the alignment-wait state. Any valid non-comma character restarts that count. While in alignment-wait with `deskew_done_i` low, the lane reports 111 regardless of the other lanes.
- R4: In bonded mode (`bond_mode_i`=1), the locked code 010 appears on all lanes in the same cycle. This happens only after a cycle in which all lanes were in alignment-wait, `deskew_done_i` was high, and every lane had a valid, error-free, non-comma character. Otherwise no lane locks.
- R5: A lane in alignment-wait with `deskew_done_i` high does not report 111. It reports 011 for a comma and 000 for other characters, so lock can show 010 with no 111 beforehand.
- R6: While locked, CONSEC_LIM (default 5) consecutive decode-errored codewords on a lane cause loss of sync. Four do not. In bonded mode all lanes drop together.
- R7: While locked, WIN_ERR_LIM (default 9) errored codewords within one block of WIN_LEN (default 16) codewords cause loss of sync. Eight errors in a block do not.
- R8: A valid comma on a locked lane leaves it locked (010) and clears both its consecutive-error count and its block count.
- R9: `lol_o[i]` equals the inverse of `pll_lock_i[i]` with no clock delay. In bonded mode, a PLL unlock on any lane while locked returns all lanes to searching at the next edge.
- R10: After CLKOFF_LIM (default 16) consecutive sampled cycles with `refclk_en_i` low, every lane is in searching at that edge. After CLKOFF_LIM-1 such cycles the lock is kept.
- R11: In independent mode (`bond_mode_i`=0), a lane in alignment-wait locks (010) on its own first valid clean data character, whatever the other lanes do.
- R12: In independent mode, a lane whose PLL was unlocked on the previous edge reports 101.
- R13: In searching or acquiring, a valid non-comma character with a decode error reports 100. A clean one, or no valid character, reports 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel character clock |
| rst | input | 1 | Synchronous active-high reset |
| bond_mode_i | input | 1 | 1 = lanes bonded, 0 = lanes independent |
| refclk_en_i | input | 1 | Reference clock enable; low for CLKOFF_LIM cycles forces searching |
| deskew_done_i | input | 1 | Deskew logic reports lanes aligned |
| char_valid_i | input | LANES | Per-lane character strobe |
| comma_i | input | LANES | Per-lane comma detected on this character |
| dec_err_i | input | LANES | Per-lane decode error on this character |
| pll_lock_i | input | LANES | Per-lane PLL locked |
| status_o | output | 3*LANES | Per-lane {err, eof, kflag} status code |
| lol_o | output | LANES | Per-lane loss of lock, unregistered |

## Verification
A lane stuck in the wrong state shows a wrong status code one edge after the character that should have moved it. A consecutive-comma counter that is off by one shows up as 111 appearing one comma early or late. Faults in the error counters only become visible when the boundary count is reached: the lock survives the fifth error, or it falls on the fourth error or the eighth errored codeword. A fault in the bonded linkage shows as 010 arriving on some lanes but not others in the same cycle, or as a lock or drop that is not reflected on the other lanes at that same edge.

// File: rtl/lbs_pkg.sv
package lbs_pkg;

  typedef enum logic [1:0] {
    ST_NOSYNC = 2'd0,
    ST_ACQ    = 2'd1,
    ST_RESYNC = 2'd2,
    ST_INSYNC = 2'd3
  } lane_st_e;

  // status code bit order: {err, eof, kflag}
  localparam logic [2:0] CODE_IDLE   = 3'b000;
  localparam logic [2:0] CODE_COMMA  = 3'b011;
  localparam logic [2:0] CODE_ALIGN  = 3'b111;
  localparam logic [2:0] CODE_BONDED = 3'b010;
  localparam logic [2:0] CODE_PLLOFF = 3'b101;
  localparam logic [2:0] CODE_BADCHR = 3'b100;

endpackage

// File: rtl/lbs_clkoff_watch.sv
module lbs_clkoff_watch #(
  parameter int CLKOFF_LIM = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic refclk_en_i,
  output logic force_o
);
  localparam int CW = $clog2(CLKOFF_LIM + 1);
  localparam logic [CW-1:0] SAT  = CW'(CLKOFF_LIM);
  localparam logic [CW-1:0] TRIP = CW'(CLKOFF_LIM - 1);

  logic [CW-1:0] low_cnt_q;

  always_ff @(posedge clk) begin
    if (rst || refclk_en_i) begin
      low_cnt_q <= '0;
    end else if (low_cnt_q != SAT) begin
      low_cnt_q <= low_cnt_q + CW'(1);
    end
  end

  // trips on the edge that samples the CLKOFF_LIM-th low cycle
  assign force_o = !refclk_en_i && (low_cnt_q >= TRIP);

endmodule

// File: rtl/lbs_err_monitor.sv
module lbs_err_monitor #(
  parameter int CONSEC_LIM  = 5,
  parameter int WIN_LEN     = 16,
  parameter int WIN_ERR_LIM = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic active_i,
  input  logic char_valid_i,
  input  logic comma_i,
  input  logic dec_err_i,
  output logic fail_o
);
  localparam int CW = $clog2(CONSEC_LIM + 1);
  localparam int WW = $clog2(WIN_LEN + 1);
  localparam logic [CW-1:0] RUN_SAT  = CW'(CONSEC_LIM);
  localparam logic [CW-1:0] RUN_TRIP = CW'(CONSEC_LIM - 1);
  localparam logic [WW-1:0] POS_LAST = WW'(WIN_LEN - 1);
  localparam logic [WW-1:0] BAD_TRIP = WW'(WIN_ERR_LIM - 1);

  logic [CW-1:0] run_q;
  logic [WW-1:0] pos_q;
  logic [WW-1:0] bad_q;
  logic          word;
  logic          bad;
  logic          restart;

  assign word    = char_valid_i && !comma_i;
  assign bad     = word && dec_err_i;
  assign restart = rst || !active_i || (char_valid_i && comma_i);

  always_ff @(posedge clk) begin
    if (restart) begin
      run_q <= '0;
      pos_q <= '0;
      bad_q <= '0;
    end else if (word) begin
      if (bad) begin
        if (run_q != RUN_SAT) run_q <= run_q + CW'(1);
      end else begin
        run_q <= '0;
      end
      if (pos_q == POS_LAST) begin
        pos_q <= '0;
        bad_q <= '0;
      end else begin
        pos_q <= pos_q + WW'(1);
        bad_q <= bad_q + WW'(bad);
      end
    end
  end

  assign fail_o = active_i && bad && ((run_q >= RUN_TRIP) || (bad_q >= BAD_TRIP));

endmodule

// File: rtl/lbs_lane_fsm.sv
module lbs_lane_fsm
  import lbs_pkg::*;
#(
  parameter int ACQ_COMMAS = 4
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     char_valid_i,
  input  logic     comma_i,
  input  logic     dec_err_i,
  input  logic     pll_ok_i,
  input  logic     force_i,
  input  logic     solo_i,
  input  logic     deskew_done_i,
  input  logic     group_lock_i,
  input  logic     group_drop_i,
  input  logic     own_fail_i,
  output lane_st_e state_o,
  output logic [2:0] status_o
);
  localparam int AW = $clog2(ACQ_COMMAS + 1);
  localparam logic [AW-1:0] ACQ_LAST = AW'(ACQ_COMMAS - 1);

  lane_st_e      st_q, st_d;
  logic [AW-1:0] cnt_q, cnt_d;
  logic [2:0]    code_d;
  logic          got_comma, got_data, got_bad;

  assign got_comma = char_valid_i && comma_i;
  assign got_data  = char_valid_i && !comma_i && !dec_err_i;
  assign got_bad   = char_valid_i && !comma_i && dec_err_i;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (force_i || !pll_ok_i) begin
      st_d  = ST_NOSYNC;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        ST_NOSYNC: begin
          if (got_comma) begin
            st_d  = ST_ACQ;
            cnt_d = AW'(1);
          end
        end
        ST_ACQ: begin
          if (got_comma) begin
            if (cnt_q >= ACQ_LAST) st_d = ST_RESYNC;
            else                   cnt_d = cnt_q + AW'(1);
          end else if (char_valid_i) begin
            cnt_d = '0;
          end
        end
        ST_RESYNC: begin
          if (solo_i ? got_data : group_lock_i) st_d = ST_INSYNC;
        end
        ST_INSYNC: begin
          if (solo_i ? own_fail_i : group_drop_i) begin
            st_d  = ST_NOSYNC;
            cnt_d = '0;
          end
        end
        default: begin
          st_d  = ST_NOSYNC;
          cnt_d = '0;
        end
      endcase
    end
  end

  // status follows the state being entered, registered with it
  always_comb begin
    if (solo_i && !pll_ok_i) begin
      code_d = CODE_PLLOFF;
    end else begin
      unique case (st_d)
        ST_INSYNC: code_d = CODE_BONDED;
        ST_RESYNC: code_d = !deskew_done_i ? CODE_ALIGN :
                            (got_comma ? CODE_COMMA : CODE_IDLE);
        default:   code_d = got_comma ? CODE_COMMA :
                            (got_bad ? CODE_BADCHR : CODE_IDLE);
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_NOSYNC;
      cnt_q    <= '0;
      status_o <= CODE_IDLE;
    end else begin
      st_q     <= st_d;
      cnt_q    <= cnt_d;
      status_o <= code_d;
    end
  end

  assign state_o = st_q;

endmodule

// File: rtl/lane_bond_sync.sv
module lane_bond_sync
  import lbs_pkg::*;
#(
  parameter int LANES       = 4,
  parameter int ACQ_COMMAS  = 4,
  parameter int CONSEC_LIM  = 5,
  parameter int WIN_LEN     = 16,
  parameter int WIN_ERR_LIM = 9,
  parameter int CLKOFF_LIM  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bond_mode_i,
  input  logic               refclk_en_i,
  input  logic               deskew_done_i,
  input  logic [LANES-1:0]   char_valid_i,
  input  logic [LANES-1:0]   comma_i,
  input  logic [LANES-1:0]   dec_err_i,
  input  logic [LANES-1:0]   pll_lock_i,
  output logic [3*LANES-1:0] status_o,
  output logic [LANES-1:0]   lol_o
);
  lane_st_e             lane_st [LANES];
  logic [LANES-1:0]     in_resync;
  logic [LANES-1:0]     in_sync;
  logic [LANES-1:0]     data_ok;
  logic [LANES-1:0]     lane_fail;
  logic [2*LANES-1:0]   st_flat;
  logic                 force_all;
  logic                 group_lock;
  logic                 group_drop;

  lbs_clkoff_watch #(.CLKOFF_LIM(CLKOFF_LIM)) u_clkoff (
    .clk         (clk),
    .rst         (rst),
    .refclk_en_i (refclk_en_i),
    .force_o     (force_all)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign data_ok[g]   = char_valid_i[g] && !comma_i[g] && !dec_err_i[g];
    assign in_resync[g] = (lane_st[g] == ST_RESYNC);
    assign in_sync[g]   = (lane_st[g] == ST_INSYNC);
    assign st_flat[2*g +: 2] = lane_st[g];

    lbs_err_monitor #(
      .CONSEC_LIM  (CONSEC_LIM),
      .WIN_LEN     (WIN_LEN),
      .WIN_ERR_LIM (WIN_ERR_LIM)
    ) u_mon (
      .clk          (clk),
      .rst          (rst),
      .active_i     (in_sync[g] && pll_lock_i[g] && !force_all),
      .char_valid_i (char_valid_i[g]),
      .comma_i      (comma_i[g]),
      .dec_err_i    (dec_err_i[g]),
      .fail_o       (lane_fail[g])
    );

    lbs_lane_fsm #(.ACQ_COMMAS(ACQ_COMMAS)) u_fsm (
      .clk           (clk),
      .rst           (rst),
      .char_valid_i  (char_valid_i[g]),
      .comma_i       (comma_i[g]),
      .dec_err_i     (dec_err_i[g]),
      .pll_ok_i      (pll_lock_i[g]),
      .force_i       (force_all),
      .solo_i        (!bond_mode_i),
      .deskew_done_i (deskew_done_i),
      .group_lock_i  (group_lock),
      .group_drop_i  (group_drop),
      .own_fail_i    (lane_fail[g]),
      .state_o       (lane_st[g]),
      .status_o      (status_o[3*g +: 3])
    );
  end

  // bonded linkage: enter together, leave together
  assign group_lock = bond_mode_i && deskew_done_i && !force_all &&
                      (&in_resync) && (&data_ok) && (&pll_lock_i);
  assign group_drop = bond_mode_i && (|in_sync) &&
                      ((|lane_fail) || !(&pll_lock_i));

  assign lol_o = ~pll_lock_i;

endmodule

// File: rtl/lbs_checker.sv
module lbs_checker
  import lbs_pkg::*;
#(
  parameter int LANES      = 4,
  parameter int CLKOFF_LIM = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               bond_mode_i,
  input logic               refclk_en_i,
  input logic               deskew_done_i,
  input logic [LANES-1:0]   pll_lock_i,
  input logic [2*LANES-1:0] st_flat,
  input logic [3*LANES-1:0] status_o
);
  localparam int OW = $clog2(CLKOFF_LIM + 1);
  localparam logic [OW-1:0] OFF_SAT = OW'(CLKOFF_LIM);

  logic [LANES-1:0] locked_v;
  logic [OW-1:0]    off_cnt;

  for (genvar g = 0; g < LANES; g++) begin : g_v
    assign locked_v[g] = (st_flat[2*g +: 2] == ST_INSYNC);
  end

  always_ff @(posedge clk) begin
    if (rst || refclk_en_i) off_cnt <= '0;
    else if (off_cnt != OFF_SAT) off_cnt <= off_cnt + OW'(1);
  end

  AST_GROUP_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (bond_mode_i && $past(bond_mode_i) && ($past(locked_v) == '0) && (locked_v != '0))
    |-> (&locked_v)); // R4

  for (genvar g = 0; g < LANES; g++) begin : g_chk
    AST_ALIGN_CODE: assert property (@(posedge clk) disable iff (rst)
      ((st_flat[2*g +: 2] == ST_RESYNC) && !$past(deskew_done_i))
      |-> (status_o[3*g +: 3] == CODE_ALIGN)); // R3

    AST_UNLOCK_DROP: assert property (@(posedge clk) disable iff (rst)
      $past(!pll_lock_i[g]) |-> (st_flat[2*g +: 2] == ST_NOSYNC)); // R9

    AST_SOLO_PLLOFF: assert property (@(posedge clk) disable iff (rst)
      $past(!bond_mode_i && !pll_lock_i[g]) |-> (status_o[3*g +: 3] == CODE_PLLOFF)); // R12

    AST_CLKOFF_FORCE: assert property (@(posedge clk) disable iff (rst)
      (off_cnt == OFF_SAT) |-> (st_flat[2*g +: 2] == ST_NOSYNC)); // R10
  end

endmodule

bind lane_bond_sync lbs_checker #(.LANES(LANES), .CLKOFF_LIM(CLKOFF_LIM)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .bond_mode_i   (bond_mode_i),
  .refclk_en_i   (refclk_en_i),
  .deskew_done_i (deskew_done_i),
  .pll_lock_i    (pll_lock_i),
  .st_flat       (st_flat),
  .status_o      (status_o)
);

// File: tb/sim_lane_bond_sync.sv
module sim_lane_bond_sync;
  localparam int L = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         bond = 1'b1;
  logic         ref_en = 1'b1;
  logic         deskew = 1'b1;
  logic [L-1:0] cval = '0;
  logic [L-1:0] comma = '0;
  logic [L-1:0] derr = '0;
  logic [L-1:0] plock = '1;
  logic [3*L-1:0] status;
  logic [L-1:0] lol;

  int nchk = 0;
  int nerr = 0;

  always #2 clk = ~clk;  // 250 MHz

  lane_bond_sync u0 (
    .clk           (clk),
    .rst           (rst),
    .bond_mode_i   (bond),
    .refclk_en_i   (ref_en),
    .deskew_done_i (deskew),
    .char_valid_i  (cval),
    .comma_i       (comma),
    .dec_err_i     (derr),
    .pll_lock_i    (plock),
    .status_o      (status),
    .lol_o         (lol)
  );

  task automatic chk(input int lane, input logic [2:0] exp, input string tag);
    nchk++;
    if (status[3*lane +: 3] !== exp) begin
      nerr++;
      $display("FAIL %s lane %0d status=%b expected=%b", tag, lane,
               status[3*lane +: 3], exp);
    end
  endtask

  task automatic chk_all(input logic [2:0] exp, input string tag);
    for (int i = 0; i < L; i++) chk(i, exp, tag);
  endtask

  task automatic chk_lol(input logic [L-1:0] exp, input string tag);
    nchk++;
    if (lol !== exp) begin
      nerr++;
      $display("FAIL %s lol=%b expected=%b", tag, lol, exp);
    end
  endtask

  // one character per lane, sampled at the next edge, checked just after it
  task automatic cyc(input logic [L-1:0] cm, input logic [L-1:0] em);
    cval  = '1;
    comma = cm;
    derr  = em;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst = 1'b1; bond = 1'b1; ref_en = 1'b1; deskew = 1'b1;
    cval = '0; comma = '0; derr = '0; plock = '1;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
  endtask

  task automatic bring_up();
    do_reset();
    repeat (4) cyc('1, '0);
    cyc('0, '0);
    chk_all(3'b010, "R4 bring-up lock");
  endtask

  task automatic t_reset();
    do_reset();
    rst = 1'b1; cval = '1; comma = '1;
    @(posedge clk); #1;
    chk_all(3'b000, "R1 status in reset");
    chk_lol('0, "R1 lol in reset");
    rst = 1'b0;
  endtask

  task automatic t_bond_acquire();
    do_reset();
    deskew = 1'b0;
    cyc('1, '0);
    chk_all(3'b011, "R2 first comma");
    cyc('1, '0);
    cyc('1, '0);
    cyc(4'b0001, '0);
    chk(0, 3'b111, "R3 lane0 fourth comma");
    chk(1, 3'b000, "R3 lane1 count broken by data");
    cyc('1, '0);
    cyc('1, '0);
    cyc('1, '0);
    chk(0, 3'b111, "R3 lane0 stays in align wait");
    chk(1, 3'b011, "R3 lane1 third comma only");
    cyc('1, '0);
    chk_all(3'b111, "R3 all lanes align wait");
    cyc('0, '0);
    chk_all(3'b111, "R4 no lock without deskew");
    deskew = 1'b1;
    cyc('0, '0);
    chk_all(3'b010, "R4 joint lock");
  endtask

  task automatic t_skip_align();
    do_reset();
    repeat (4) cyc('1, '0);
    chk_all(3'b011, "R5 no 111 with deskew high");
    cyc(4'b0001, '0);
    chk(0, 3'b011, "R5 lane0 comma in align wait");
    chk(1, 3'b000, "R4 no lock when one lane sends comma");
    cyc('0, '0);
    chk_all(3'b010, "R5 direct lock");
  endtask

  task automatic t_consec();
    bring_up();
    repeat (4) cyc('0, 4'b0010);
    chk_all(3'b010, "R6 four errors keep lock");
    cyc('0, 4'b0010);
    chk(0, 3'b000, "R6 fifth error drops lane0");
    chk(1, 3'b100, "R13 errored lane after drop");
    chk(3, 3'b000, "R6 fifth error drops lane3");
    cyc('0, '0);
    chk(1, 3'b000, "R13 clean char in searching");
  endtask

  task automatic t_rate();
    bring_up();
    for (int k = 0; k < 16; k++) cyc('0, (k % 2 == 0) ? 4'b0100 : 4'b0000);
    chk_all(3'b010, "R7 eight errors in block keep lock");
    for (int k = 0; k < 12; k++) cyc('0, (k % 3 != 2) ? 4'b0100 : 4'b0000);
    chk_all(3'b010, "R7 eight errors so far");
    cyc('0, 4'b0100);
    chk(2, 3'b100, "R7 ninth error drops lane2");
    chk(0, 3'b000, "R7 ninth error drops lane0");
  endtask

  task automatic t_comma_clear();
    bring_up();
    repeat (4) cyc('0, 4'b1000);
    cyc(4'b1000, '0);
    chk_all(3'b010, "R8 comma keeps lock");
    repeat (4) cyc('0, 4'b1000);
    chk_all(3'b010, "R8 run restarted by comma");
  endtask

  task automatic t_pll();
    bring_up();
    plock = 4'b1011;
    #1;
    chk_lol(4'b0100, "R9 lol follows pll without clock");
    cyc('0, '0);
    chk_all(3'b000, "R9 unlock drops all lanes");
    plock = '1;
    #1;
    chk_lol(4'b0000, "R9 lol clears");
  endtask

  task automatic t_clkoff();
    bring_up();
    ref_en = 1'b0;
    repeat (CLKOFF_N - 1) cyc('0, '0);
    chk_all(3'b010, "R10 fifteen low cycles keep lock");
    cyc('0, '0);
    chk_all(3'b000, "R10 sixteenth low cycle forces searching");
    ref_en = 1'b1;
  endtask

  task automatic t_indep();
    do_reset();
    bond = 1'b0; deskew = 1'b0;
    repeat (4) cyc(4'b0001, '0);
    chk(0, 3'b111, "R3 solo lane0 align wait");
    chk(1, 3'b000, "R13 idle lane1");
    cyc('0, '0);
    chk(0, 3'b010, "R11 lane0 locks alone");
    chk(1, 3'b000, "R11 lane1 not locked");
    plock = 4'b1110;
    cyc('0, '0);
    chk(0, 3'b101, "R12 unlocked lane code");
    chk(1, 3'b000, "R12 other lane unaffected");
    plock = '1;
  endtask

  task automatic t_reset_locked();
    bring_up();
    rst = 1'b1;
    @(posedge clk); #1;
    rst = 1'b0;
    cyc('0, '0);
    chk_all(3'b000, "R1 reset from lock");
  endtask

  localparam int CLKOFF_N = 16;

  initial begin
    #(4 * 20000);
    nerr++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    t_reset();
    t_bond_acquire();
    t_skip_align();
    t_consec();
    t_rate();
    t_comma_clear();
    t_pll();
    t_clkoff();
    t_indep();
    t_reset_locked();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule